// File: doc/BRIEF.md
# Buffered-Duty Pulse-Width Modulator

This block makes a single pulse-width-modulated output from a bus register interface. Software sets a period length and a clock divide ratio, then writes duty values. Each duty value goes into a four-entry queue rather than straight to the comparator. The period counter takes a new duty value from the queue at the moment it is enabled and again at every period boundary. Software can therefore queue several duty values ahead of time, and each one is used for exactly one period. When the queue runs dry, the most recent value stays in force.

The period counter advances once per divided clock and counts through the period register value plus two before it wraps. The output is high from the start of a period until the counter reaches the active duty value. A software reset bit clears the queue, the counter, the active duty value and the control word in one write. It reads back as set for a single cycle. Clearing the enable bit stops the counter at zero and forces the output low. Duty writes made while the block is disabled still fill the queue.

Top module: `pwm_fifo_gen`

## Requirements
- R1: The control word is at offset 0x00. Bit 0 is enable, bits 15:4 are the divide field, bits 17:16 are a clock-select field, and bits 22, 23 and 24 are three stored low-power flags. All of these read back as written. Every other control bit reads 0 except bit 3, which is covered by R9. After reset every register reads 0.
- R2: Offset 0x04 is status. Bits 2:0 give the number of queued duty values, from 0 to 4, and all other bits read 0.
- R3: A duty write to offset 0x0C while four values are queued is discarded, and the occupancy does not change.
- R4: When the divide field holds N, the period counter advances once every N+1 clock cycles.
- R5: One output period lasts the value at offset 0x10 plus 2 counter steps.
- R6: The output is high while the counter is below the active duty value, so that value counts the high steps from the start of each period. A value of 0 keeps the output low, and a value of at least the period length keeps it high.
- R7: At the write that sets enable from 0, and at every period wrap, the oldest queued value becomes active and its slot is freed.
- R8: If the queue is empty when a value would be taken, the active duty value stays as it was.
- R9: A control write with bit 3 set clears the queue, the counter, the active duty value and the whole control word. It leaves the period register unchanged. Control bit 3 reads 1 in the cycle after that write and 0 from the cycle after that.
- R10: While enable is 0, the output stays low, the counter is held at zero and the queue is never drained.
- R11: A read of offset 0x0C returns the active duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong queue pointer or occupancy shows up one access later. The status field or the active-duty readback disagrees, and the pulse width changes at the next period boundary. A counter or divider error moves an output edge within a single period of the waveform. The bench compares the output against its model on every clock, so such an error is reported within a few cycles. A duty value taken at the wrong time shifts the pattern of high times from one period to the next, and a discarded write that was wrongly accepted appears as an extra period with the wrong duty.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    localparam int BUS_W   = 32;
    localparam int PRE_W   = 12;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_SAMP = 8'h0C;
    localparam logic [7:0] OFS_PER  = 8'h10;

    localparam int BIT_EN   = 0;
    localparam int BIT_SRST = 3;
    localparam int PRE_LSB  = 4;

    // enable, divide field, clock select, three low-power flags
    localparam logic [BUS_W-1:0] CTRL_KEEP = 32'h01C3_FFF1;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_STAT,
        RSEL_SAMP,
        RSEL_PER
    } reg_sel_e;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] div;
    } wave_cfg_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_CTRL: return RSEL_CTRL;
            OFS_STAT: return RSEL_STAT;
            OFS_SAMP: return RSEL_SAMP;
            OFS_PER:  return RSEL_PER;
            default:  return RSEL_NONE;
        endcase
    endfunction

    function automatic wave_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        wave_cfg_t c;
        c.run = w[BIT_EN];
        c.div = w[PRE_LSB +: PRE_W];
        return c;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int OCC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [OCC_W-1:0]  occ,
    input  logic [DATA_W-1:0] active_duty,
    output logic [BUS_W-1:0]  bus_rdata,
    output wave_cfg_t         cfg,
    output logic [DATA_W-1:0] period,
    output logic              soft_clr,
    output logic              halt,
    output logic              start,
    output logic              duty_wr,
    output logic [DATA_W-1:0] duty_wdata
);

    logic [BUS_W-1:0] ctrl_q;
    logic             busy_q;
    logic [7:0]       ofs;
    reg_sel_e         rsel;
    logic             ctrl_wr;
    logic             per_wr;

    always_comb begin
        ofs = '0;
        ofs[ADDR_W-1:0] = bus_addr;
    end

    assign rsel     = decode_ofs(ofs);
    assign ctrl_wr  = bus_sel && bus_wr && (rsel == RSEL_CTRL);
    assign per_wr   = bus_sel && bus_wr && (rsel == RSEL_PER);
    assign duty_wr  = bus_sel && bus_wr && (rsel == RSEL_SAMP);
    assign duty_wdata = bus_wdata[DATA_W-1:0];

    assign soft_clr = ctrl_wr && bus_wdata[BIT_SRST];
    assign halt     = ctrl_wr && (!bus_wdata[BIT_EN] || bus_wdata[BIT_SRST]);
    assign start    = ctrl_wr && bus_wdata[BIT_EN] && !bus_wdata[BIT_SRST] && !ctrl_q[BIT_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            busy_q <= 1'b0;
            period <= '0;
        end else begin
            busy_q <= soft_clr;
            if (soft_clr) begin
                ctrl_q <= '0;
            end else if (ctrl_wr) begin
                ctrl_q <= bus_wdata & CTRL_KEEP;
            end
            if (per_wr) begin
                period <= bus_wdata[DATA_W-1:0];
            end
        end
    end

    assign cfg = cfg_from_word(ctrl_q);

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            RSEL_CTRL: begin
                bus_rdata = ctrl_q;
                bus_rdata[BIT_SRST] = busy_q;
            end
            RSEL_STAT: bus_rdata[OCC_W-1:0]  = occ;
            RSEL_SAMP: bus_rdata[DATA_W-1:0] = active_duty;
            RSEL_PER:  bus_rdata[DATA_W-1:0] = period;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic [OCC_W-1:0]  occ
);

    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign empty   = (occ == '0);
    assign do_push = push && (occ != FULL_OCC);
    assign do_pop  = pop && !empty;
    assign head    = slot[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot[i] <= '0;
                end else if (do_push && (wr_ptr == PTR_W'(i))) begin
                    slot[i] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core
    import pwm_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CNT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wave_cfg_t         cfg,
    input  logic [DATA_W-1:0] period,
    input  logic              soft_clr,
    input  logic              halt,
    input  logic              start,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    output logic              take,
    output logic [DATA_W-1:0] active_duty,
    output logic [CNT_W-1:0]  cnt,
    output logic              pwm_out
);

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] last_step;

    assign last_step = {1'b0, period} + 1'b1;
    assign tick      = cfg.run && (pre_q == cfg.div);
    assign wrap      = tick && (cnt >= last_step);
    assign take      = (start || wrap) && !q_empty && !soft_clr;

    always_ff @(posedge clk) begin
        if (rst || halt || !cfg.run) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt   <= wrap ? '0 : cnt + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            active_duty <= '0;
        end else if (take) begin
            active_duty <= q_head;
        end
    end

    assign pwm_out = cfg.run && (cnt < {1'b0, active_duty});

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 5,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int CNT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);

    wave_cfg_t         cfg;
    logic [DATA_W-1:0] period;
    logic              soft_clr;
    logic              halt;
    logic              start;
    logic              duty_wr;
    logic [DATA_W-1:0] duty_wdata;
    logic [OCC_W-1:0]  occ;
    logic              q_empty;
    logic [DATA_W-1:0] q_head;
    logic              take;
    logic [DATA_W-1:0] active_duty;
    logic [CNT_W-1:0]  cnt;
    logic              run_en;

    assign run_en = cfg.run;

    pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .occ         (occ),
        .active_duty (active_duty),
        .bus_rdata   (bus_rdata),
        .cfg         (cfg),
        .period      (period),
        .soft_clr    (soft_clr),
        .halt        (halt),
        .start       (start),
        .duty_wr     (duty_wr),
        .duty_wdata  (duty_wdata)
    );

    pwm_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_clr),
        .push  (duty_wr),
        .wdata (duty_wdata),
        .pop   (take),
        .head  (q_head),
        .empty (q_empty),
        .occ   (occ)
    );

    pwm_wave_core #(.DATA_W(DATA_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .period      (period),
        .soft_clr    (soft_clr),
        .halt        (halt),
        .start       (start),
        .q_empty     (q_empty),
        .q_head      (q_head),
        .take        (take),
        .active_duty (active_duty),
        .cnt         (cnt),
        .pwm_out     (pwm_out)
    );

endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int CNT_W = DATA_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             duty_wr,
    input logic             soft_clr,
    input logic             take,
    input logic             run_en,
    input logic [OCC_W-1:0] occ,
    input logic [CNT_W-1:0] cnt,
    input logic             pwm_out
);

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(DEPTH) && duty_wr && !take && !soft_clr) |=> (occ == OCC_W'(DEPTH)));

    p_single_take_r7: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && occ != '0) |=> (occ + 1'b1 >= $past(occ)));

    p_clear_all_r9: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!run_en && occ == '0 && cnt == '0));

    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!run_en -> (cnt == '0 && !pwm_out)));

endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .duty_wr  (duty_wr),
    .soft_clr (soft_clr),
    .take     (take),
    .run_en   (run_en),
    .occ      (occ),
    .cnt      (cnt),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_fifo_gen_bench.sv
`timescale 1ns/1ps
module pwm_fifo_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_fifo_gen u_pwm_fifo_gen (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // behavioural reference model
    int       m_ctrl, m_per, m_cnt, m_pre, m_cur, m_div;
    bit       m_en, m_busy;
    int       q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_per = 0; m_cnt = 0; m_pre = 0; m_cur = 0; m_div = 0;
            m_en = 0; m_busy = 0; q.delete();
        end else begin
            bit wc, ws, wp, srst, halt, start, tick, wrap, take, acc;
            wc = bus_sel && bus_wr && bus_addr == 5'h00;
            ws = bus_sel && bus_wr && bus_addr == 5'h0C;
            wp = bus_sel && bus_wr && bus_addr == 5'h10;
            srst  = wc && bus_wdata[3];
            halt  = wc && (!bus_wdata[0] || bus_wdata[3]);
            start = wc && bus_wdata[0] && !bus_wdata[3] && !m_en;
            tick  = m_en && (m_pre == m_div);
            wrap  = tick && (m_cnt >= m_per + 1);
            take  = (start || wrap) && q.size() > 0 && !srst;
            acc   = ws && q.size() < 4;
            m_busy = srst;
            if (srst) begin
                m_ctrl = 0; m_en = 0; m_div = 0; q.delete();
                m_cnt = 0; m_pre = 0; m_cur = 0;
            end else begin
                if (take) m_cur = q.pop_front();
                if (acc) q.push_back(int'(bus_wdata[15:0]));
                if (halt || !m_en) begin
                    m_cnt = 0; m_pre = 0;
                end else if (tick) begin
                    m_pre = 0;
                    m_cnt = wrap ? 0 : m_cnt + 1;
                end else begin
                    m_pre = m_pre + 1;
                end
                if (wc) begin
                    m_ctrl = int'(bus_wdata & 32'h01C3_FFF1);
                    m_en   = bus_wdata[0];
                    m_div  = int'(bus_wdata[15:4]);
                end
            end
            if (wp) m_per = int'(bus_wdata[15:0]);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle output comparison: R5 R6 R7 R8
    always begin
        @(negedge clk);
        #1;
        if (!rst && !done) begin
            bit e;
            e = m_en && (m_cnt < m_cur);
            check(pwm_out == e, "R5 R6 R7 R8 waveform", 32'(pwm_out), 32'(e));
        end
    end

    task automatic op_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            #1;
            h += int'(pwm_out);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int h;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R11: reset state
        rd_chk(5'h00, 32'h0, "R1 reset ctrl");
        rd_chk(5'h04, 32'h0, "R2 reset status");
        rd_chk(5'h0C, 32'h0, "R11 reset duty");
        rd_chk(5'h10, 32'h0, "R1 reset period");

        // R1: field readback
        op_wr(5'h00, 32'h01C3_5670);
        rd_chk(5'h00, 32'h01C3_5670, "R1 ctrl fields");
        op_wr(5'h00, 32'hFFFF_FFF6);
        rd_chk(5'h00, 32'h01C3_FFF0, "R1 ctrl reserved bits");
        op_wr(5'h00, 32'h0);

        // R2 R3 R10: fill queue while disabled
        op_wr(5'h0C, 32'd2);
        op_wr(5'h0C, 32'd0);
        op_wr(5'h0C, 32'd7);
        rd_chk(5'h04, 32'd3, "R2 three queued");
        op_wr(5'h0C, 32'd5);
        rd_chk(5'h04, 32'd4, "R2 full");
        op_wr(5'h0C, 32'd9);
        rd_chk(5'h04, 32'd4, "R3 write while full dropped");
        count_high(10, h);
        check(h == 0, "R10 low while disabled", 32'(h), 32'd0);
        rd_chk(5'h04, 32'd4, "R10 queue kept while disabled");

        // R7 R11: enable takes first value
        op_wr(5'h10, 32'd3);
        op_wr(5'h00, 32'h1);
        rd_chk(5'h0C, 32'd2, "R7 R11 first value active");
        rd_chk(5'h04, 32'd3, "R7 slot freed");
        count_high(40, h);
        rd_chk(5'h04, 32'd0, "R7 queue drained");
        rd_chk(5'h0C, 32'd5, "R3 R8 last value kept");
        count_high(10, h);
        check(h == 10, "R6 full duty", 32'(h), 32'd10);

        // R6: zero duty
        op_wr(5'h0C, 32'd0);
        count_high(6, h);
        count_high(15, h);
        check(h == 0, "R6 zero duty", 32'(h), 32'd0);

        // R10: disable while running
        op_wr(5'h0C, 32'd3);
        count_high(6, h);
        op_wr(5'h00, 32'h0);
        count_high(8, h);
        check(h == 0, "R10 disable forces low", 32'(h), 32'd0);
        rd_chk(5'h0C, 32'd3, "R11 duty after disable");

        // R9: software reset flushes queue
        op_wr(5'h0C, 32'd4);
        op_wr(5'h0C, 32'd4);
        op_wr(5'h00, 32'h8);
        rd_chk(5'h00, 32'h8, "R9 reset bit busy");
        rd_chk(5'h00, 32'h0, "R9 reset bit cleared");
        rd_chk(5'h04, 32'h0, "R9 queue flushed");
        rd_chk(5'h0C, 32'h0, "R9 duty cleared");
        rd_chk(5'h10, 32'd3, "R9 period kept");

        // R5: period = value + 2
        op_wr(5'h0C, 32'd2);
        op_wr(5'h00, 32'h1);
        count_high(20, h);
        check(h == 8, "R5 period length", 32'(h), 32'd8);
        op_wr(5'h00, 32'h8);

        // R4: divider
        op_wr(5'h10, 32'd1);
        op_wr(5'h0C, 32'd1);
        op_wr(5'h00, 32'h21);
        count_high(18, h);
        check(h == 6, "R4 divide by three", 32'(h), 32'd6);

        // R9 while running, R8 empty queue after re-enable
        op_wr(5'h0C, 32'd1);
        op_wr(5'h0C, 32'd1);
        op_wr(5'h00, 32'h8);
        count_high(10, h);
        check(h == 0, "R9 output low after reset", 32'(h), 32'd0);
        rd_chk(5'h04, 32'h0, "R9 queue empty");
        op_wr(5'h00, 32'h1);
        count_high(10, h);
        check(h == 0, "R8 empty queue keeps zero duty", 32'(h), 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule